// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one programmable logic cell of the kind found at the output of a product-term array. It takes a small set of already-formed product terms and sums, chooses one of them as its data term and optionally inverts it. It then passes the result both straight through and into a storage element. The storage element can be set up as an edge-triggered D register, a flow-through D latch or a toggle flip-flop. Its clock, clock enable, preset and clear each come from a selectable global or product-term source, and each of those controls has its own active polarity.

The cell has two outputs. The feedback output returns to the local array and the interconnect output goes to the wider routing. Each output independently carries either the combinational term or the stored value, so one output can hold a registered function while the other carries an unrelated combinational one. A static configuration word sets the whole cell. Clock sources are sampled on the system clock `clk`. An enabled "edge" of a selected clock source is its inactive-to-active transition as seen between two `clk` edges, and the storage update appears right after the `clk` edge that sees it. Preset and clear reach the stored value at once, without a clock.

Top module: `lmc_cell`

## Requirements
- R1: The data source field cfg[1:0] selects the data term: 0 the shared sum input `sum_in`, 1 the OR of all bypass terms `byp_pt`, 2 the single term `one_pt`, 3 constant 0.
- R2: cfg[7] = 1 inverts the selected term. The inverted value feeds both the combinational path and the storage element.
- R3: cfg[14] routes the stored value (1) or the combinational term (0) to `fb_out`. cfg[15] does the same for `ic_out`, independently of cfg[14].
- R4: In storage mode cfg[3:2] = 0 (and 3, treated the same way), an enabled active clock edge loads the data term. The new value shows right after the `clk` edge on which the edge is seen.
- R5: In storage mode 1 (latch), the stored output follows the data term in the same cycle while the selected clock is at its active level and enabled. It keeps the last value taken once the gate goes inactive.
- R6: In storage mode 2 (toggle), an enabled active clock edge inverts the stored bit when the data term is 1 and leaves it unchanged when the data term is 0.
- R7: Clock select cfg[6:4] picks `gclk[0]`..`gclk[2]` with codes 0..2, the per-cell `pt_clk` with code 3 and the group-shared `shr_clk` with code 4. Codes 5..7 never clock. With cfg[8] = 1 the active edge is the falling one.
- R8: cfg[12] picks the clock enable from `gce` (0) or `pt_ce` (1), and cfg[9] = 1 makes it active-low. A clock edge or latch gate that arrives while the enable is inactive leaves the stored value unchanged.
- R9: An active `pt_rst` clears and an active `pt_set` presets the stored value at once, with no clock. The value stays after release. cfg[11] = 1 makes `pt_rst` and `grst` active-low, and cfg[10] = 1 makes `pt_set` active-low.
- R10: An active global line `grst` presets the stored value when cfg[13] = 1 and clears it when cfg[13] = 0.
- R11: When a clear and a preset are active at the same time, from any mix of sources, the stored value is 0.
- R12: After `rst_n` the stored value is 0. A clock source held at its active level causes only one update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all sources |
| rst_n | input | 1 | Power-up reset, active low |
| cfg | input | 16 | Static configuration word |
| sum_in | input | 1 | Sum from the shared-term path |
| byp_pt | input | BYP_TERMS | Product terms of the bypass path |
| one_pt | input | 1 | Single product term |
| gclk | input | NGCLK | Global clock sources |
| pt_clk | input | 1 | Per-cell product-term clock |
| shr_clk | input | 1 | Group-shared product-term clock |
| gce | input | 1 | Global clock enable |
| pt_ce | input | 1 | Product-term clock enable |
| grst | input | 1 | Global preset/clear line |
| pt_set | input | 1 | Product-term preset |
| pt_rst | input | 1 | Product-term clear |
| fb_out | output | 1 | Output to the local array |
| ic_out | output | 1 | Output to the interconnect |

## Verification
The two functions that meet in one cycle are clear and preset. The bench raises `pt_set` together with `pt_rst`, and later the global line configured to preset together with `pt_rst`, and it expects the stored output at 0 in that very cycle. It also expects the preset value as soon as the clear is dropped. A second collision, a clock source held high across several cycles while the data term changes, is judged by requiring that the stored output does not move after the first update.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

   typedef enum logic [1:0] {
      SRC_SHARED = 2'd0,
      SRC_BYPASS = 2'd1,
      SRC_SINGLE = 2'd2,
      SRC_ZERO   = 2'd3
   } dsrc_e;

   typedef enum logic [1:0] {
      ST_DREG  = 2'd0,
      ST_LATCH = 2'd1,
      ST_TFF   = 2'd2,
      ST_DREG2 = 2'd3
   } smode_e;

   localparam int CSEL_W = 3;

   typedef struct packed {
      logic              ic_reg;
      logic              fb_reg;
      logic              gline_sets;
      logic              ce_from_pt;
      logic              rst_low;
      logic              set_low;
      logic              ce_low;
      logic              clk_fall;
      logic              invert;
      logic [CSEL_W-1:0] clk_sel;
      smode_e            mode;
      dsrc_e             dsrc;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/mc_term_sel.sv
module mc_term_sel
   import mcell_pkg::*;
#(
   parameter int BYP_TERMS = 4
) (
   input  dsrc_e                dsrc,
   input  logic                 invert,
   input  logic                 sum_in,
   input  logic [BYP_TERMS-1:0] byp_pt,
   input  logic                 one_pt,
   output logic                 d_val
);

   logic byp_or;
   logic raw;

   generate
      if (BYP_TERMS < 1 || BYP_TERMS > 16) begin : g_bad_terms
         $error("mc_term_sel: BYP_TERMS out of range");
      end
      if (BYP_TERMS == 1) begin : g_one_term
         assign byp_or = byp_pt[0];
      end else begin : g_or_terms
         assign byp_or = |byp_pt;
      end
   endgenerate

   always_comb begin
      unique case (dsrc)
         SRC_SHARED: raw = sum_in;
         SRC_BYPASS: raw = byp_or;
         SRC_SINGLE: raw = one_pt;
         default:    raw = 1'b0;
      endcase
   end

   assign d_val = raw ^ invert;

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mcell_pkg::*;
#(
   parameter int NGCLK = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CSEL_W-1:0] clk_sel,
   input  logic              clk_fall,
   input  logic              ce_from_pt,
   input  logic              ce_low,
   input  logic              set_low,
   input  logic              rst_low,
   input  logic              gline_sets,
   input  logic [NGCLK-1:0]  gclk,
   input  logic              pt_clk,
   input  logic              shr_clk,
   input  logic              gce,
   input  logic              pt_ce,
   input  logic              grst,
   input  logic              pt_set,
   input  logic              pt_rst,
   output logic              clk_edge,
   output logic              clk_level,
   output logic              ce_on,
   output logic              clr_on,
   output logic              set_on
);

   localparam int NSRC  = 1 << CSEL_W;
   localparam int PT_IX = NGCLK;
   localparam int SH_IX = NGCLK + 1;

   logic [NSRC-1:0] src;
   logic            prev_q;
   logic            gline_on;

   generate
      if (NGCLK < 1 || SH_IX >= NSRC) begin : g_bad_nclk
         $error("mc_ctrl: NGCLK does not fit the clock select field");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         if (i < NGCLK) begin : g_glob
            assign src[i] = gclk[i];
         end else if (i == PT_IX) begin : g_pt
            assign src[i] = pt_clk;
         end else if (i == SH_IX) begin : g_sh
            assign src[i] = shr_clk;
         end else begin : g_none
            assign src[i] = 1'b0;
         end
      end
   endgenerate

   assign clk_level = src[clk_sel] ^ clk_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= clk_level;
   end

   assign clk_edge = clk_level & ~prev_q;
   assign ce_on    = (ce_from_pt ? pt_ce : gce) ^ ce_low;
   assign gline_on = grst ^ rst_low;
   assign clr_on   = (pt_rst ^ rst_low) | (gline_on & ~gline_sets);
   assign set_on   = (pt_set ^ set_low) | (gline_on & gline_sets);

   // R12
   edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_edge |=> !clk_edge);

endmodule

// File: rtl/mc_store.sv
module mc_store
   import mcell_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  smode_e mode,
   input  logic   d_val,
   input  logic   clk_edge,
   input  logic   clk_level,
   input  logic   ce_on,
   input  logic   clr_on,
   input  logic   set_on,
   output logic   q_view
);

   logic q;
   logic gate_open;

   assign gate_open = (mode == ST_LATCH) && clk_level && ce_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (clr_on) begin
         q <= 1'b0;
      end else if (set_on) begin
         q <= 1'b1;
      end else begin
         unique case (mode)
            ST_LATCH: if (gate_open) q <= d_val;
            ST_TFF:   if (clk_edge && ce_on && d_val) q <= ~q;
            default:  if (clk_edge && ce_on) q <= d_val;
         endcase
      end
   end

   always_comb begin
      if (clr_on)         q_view = 1'b0;
      else if (set_on)    q_view = 1'b1;
      else if (gate_open) q_view = d_val;
      else                q_view = q;
   end

   // R4
   dreg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == ST_DREG || mode == ST_DREG2) && clk_edge && ce_on && !clr_on && !set_on)
      |=> (q == $past(d_val)));

   // R6
   tff_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == ST_TFF && clk_edge && ce_on && d_val && !clr_on && !set_on)
      |=> (q != $past(q)));

   // R8
   ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_on && !clr_on && !set_on) |=> $stable(q));

   // R11
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_on |=> (q == 1'b0));

   // R9
   preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_on && !clr_on) |=> (q == 1'b1));

endmodule

// File: rtl/lmc_cell.sv
module lmc_cell
   import mcell_pkg::*;
#(
   parameter int BYP_TERMS = 4,
   parameter int NGCLK     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [15:0]          cfg,
   input  logic                 sum_in,
   input  logic [BYP_TERMS-1:0] byp_pt,
   input  logic                 one_pt,
   input  logic [NGCLK-1:0]     gclk,
   input  logic                 pt_clk,
   input  logic                 shr_clk,
   input  logic                 gce,
   input  logic                 pt_ce,
   input  logic                 grst,
   input  logic                 pt_set,
   input  logic                 pt_rst,
   output logic                 fb_out,
   output logic                 ic_out
);

   localparam int NOUT = 2;

   generate
      if (CFG_W != 16) begin : g_bad_cfg
         $error("lmc_cell: configuration word width mismatch");
      end
   endgenerate

   cfg_t c;
   assign c = cfg_t'(cfg);

   logic d_val, clk_edge, clk_level, ce_on, clr_on, set_on, q_view;
   logic [NOUT-1:0] route_reg;
   logic [NOUT-1:0] outs;

   mc_term_sel #(.BYP_TERMS(BYP_TERMS)) u_term (
      .dsrc   (c.dsrc),
      .invert (c.invert),
      .sum_in (sum_in),
      .byp_pt (byp_pt),
      .one_pt (one_pt),
      .d_val  (d_val)
   );

   mc_ctrl #(.NGCLK(NGCLK)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_sel    (c.clk_sel),
      .clk_fall   (c.clk_fall),
      .ce_from_pt (c.ce_from_pt),
      .ce_low     (c.ce_low),
      .set_low    (c.set_low),
      .rst_low    (c.rst_low),
      .gline_sets (c.gline_sets),
      .gclk       (gclk),
      .pt_clk     (pt_clk),
      .shr_clk    (shr_clk),
      .gce        (gce),
      .pt_ce      (pt_ce),
      .grst       (grst),
      .pt_set     (pt_set),
      .pt_rst     (pt_rst),
      .clk_edge   (clk_edge),
      .clk_level  (clk_level),
      .ce_on      (ce_on),
      .clr_on     (clr_on),
      .set_on     (set_on)
   );

   mc_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (c.mode),
      .d_val     (d_val),
      .clk_edge  (clk_edge),
      .clk_level (clk_level),
      .ce_on     (ce_on),
      .clr_on    (clr_on),
      .set_on    (set_on),
      .q_view    (q_view)
   );

   assign route_reg = {c.ic_reg, c.fb_reg};

   generate
      for (genvar k = 0; k < NOUT; k++) begin : g_out
         assign outs[k] = route_reg[k] ? q_view : d_val;
      end
   endgenerate

   assign fb_out = outs[0];
   assign ic_out = outs[1];

   // R1
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c.dsrc == SRC_ZERO && !c.fb_reg) |-> (fb_out == c.invert));

endmodule

// File: tb/lmc_cell_bench.sv
module lmc_cell_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       ic_reg = 0, fb_reg = 0, gsets = 0, cesrc = 0, rlow = 0, slow = 0;
   logic       celow = 0, cfall = 0, inv = 0;
   logic [2:0] csel = 0;
   logic [1:0] mode = 0, dsrc = 0;
   logic [15:0] cfg;
   assign cfg = {ic_reg, fb_reg, gsets, cesrc, rlow, slow, celow, cfall, inv, csel, mode, dsrc};

   logic       sum_in = 0, one_pt = 0, pt_clk = 0, shr_clk = 0;
   logic       gce = 1, pt_ce = 0, grst = 0, pt_set = 0, pt_rst = 0;
   logic [3:0] byp_pt = 0;
   logic [2:0] gclk = 0;
   logic       fb_out, ic_out;

   lmc_cell u_lmc_cell (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .sum_in(sum_in), .byp_pt(byp_pt),
      .one_pt(one_pt), .gclk(gclk), .pt_clk(pt_clk), .shr_clk(shr_clk),
      .gce(gce), .pt_ce(pt_ce), .grst(grst), .pt_set(pt_set), .pt_rst(pt_rst),
      .fb_out(fb_out), .ic_out(ic_out)
   );

   logic [1:0] exq[$];
   string      tagq[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done = 0;

   // driver: inputs are already set; queue the result expected after the next edge
   task automatic go(input logic efb, input logic eic, input string tag);
      exq.push_back({efb, eic});
      tagq.push_back(tag);
      @(negedge clk);
   endtask

   // monitor: compares just after each rising edge
   always begin
      @(posedge clk);
      #1;
      if (exq.size() > 0) begin
         logic [1:0] e;
         string t;
         e = exq.pop_front();
         t = tagq.pop_front();
         n_cmp++;
         if ({fb_out, ic_out} !== e) begin
            n_bad++;
            $display("FAIL %s: fb/ic actual %b%b expected %b%b", t, fb_out, ic_out, e[1], e[0]);
         end
      end
   end

   initial begin
      #80000;
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      ic_reg = 1;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      go(0, 0, "R12");
      sum_in = 1; go(1, 0, "R3");

      // R1 data sources, both outputs combinational
      ic_reg = 0;
      go(1, 1, "R1");
      dsrc = 1; sum_in = 0; byp_pt = 4'b0100; go(1, 1, "R1");
      byp_pt = 0; go(0, 0, "R1");
      dsrc = 2; one_pt = 1; go(1, 1, "R1");
      one_pt = 0; sum_in = 1; byp_pt = 4'hf; go(0, 0, "R1");
      dsrc = 3; one_pt = 1; go(0, 0, "R1");
      // R2 inversion
      dsrc = 0; one_pt = 0; byp_pt = 0; inv = 1; sum_in = 0; go(1, 1, "R2");
      sum_in = 1; go(0, 0, "R2");

      // R4 D register, fb stored and ic combinational
      inv = 0; fb_reg = 1;
      go(0, 1, "R3");
      gclk = 3'b001; go(1, 1, "R4");
      sum_in = 0; go(1, 0, "R12");
      gclk = 3'b000; go(1, 0, "R4");
      gclk = 3'b001; go(0, 0, "R4");

      // R7 clock selection
      csel = 3; pt_clk = 0; gclk = 3'b111; sum_in = 1; go(0, 1, "R7");
      pt_clk = 1; go(1, 1, "R7");
      csel = 4; pt_clk = 0; shr_clk = 0; sum_in = 0; go(1, 0, "R7");
      shr_clk = 1; go(0, 0, "R7");
      csel = 5; sum_in = 1; gclk = 0; pt_clk = 0; shr_clk = 0; go(0, 1, "R7");
      gclk = 3'b111; pt_clk = 1; shr_clk = 1; go(0, 1, "R7");
      csel = 1; gclk = 0; pt_clk = 0; shr_clk = 0; go(0, 1, "R7");
      gclk = 3'b010; go(1, 1, "R7");
      csel = 0; cfall = 1; sum_in = 0; go(1, 0, "R7");
      gclk = 3'b011; go(1, 0, "R7");
      gclk = 3'b010; go(0, 0, "R7");

      // R8 clock enable
      cfall = 0; gclk = 0; gce = 0; sum_in = 1; go(0, 1, "R8");
      gclk = 3'b001; go(0, 1, "R8");
      gclk = 0; go(0, 1, "R8");
      cesrc = 1; pt_ce = 1; gclk = 3'b001; go(1, 1, "R8");
      cesrc = 0; celow = 1; gce = 1; pt_ce = 0; sum_in = 0; gclk = 0; go(1, 0, "R8");
      gclk = 3'b001; go(1, 0, "R8");
      gclk = 0; gce = 0; go(1, 0, "R8");
      gclk = 3'b001; go(0, 0, "R8");

      // R6 toggle
      celow = 0; gce = 1; mode = 2; sum_in = 1; gclk = 0; go(0, 1, "R6");
      gclk = 3'b001; go(1, 1, "R6");
      gclk = 0; go(1, 1, "R6");
      gclk = 3'b001; go(0, 1, "R6");
      gclk = 0; sum_in = 0; go(0, 0, "R6");
      gclk = 3'b001; go(0, 0, "R6");
      gclk = 0; sum_in = 1; go(0, 1, "R6");
      gclk = 3'b001; go(1, 1, "R6");

      // R5 latch
      mode = 1; gclk = 0; sum_in = 0; go(1, 0, "R5");
      gclk = 3'b001; go(0, 0, "R5");
      sum_in = 1; go(1, 1, "R5");
      gclk = 0; sum_in = 0; go(1, 0, "R5");
      gclk = 3'b001; gce = 0; go(1, 0, "R8");
      gclk = 0; gce = 1; go(1, 0, "R5");

      // R9 product-term preset and clear, no clock
      mode = 0; csel = 5; go(1, 0, "R9");
      pt_rst = 1; go(0, 0, "R9");
      pt_rst = 0; go(0, 0, "R9");
      pt_set = 1; go(1, 0, "R9");
      pt_set = 0; go(1, 0, "R9");
      rlow = 1; pt_rst = 1; grst = 1; go(1, 0, "R9");
      pt_rst = 0; go(0, 0, "R9");
      pt_rst = 1; go(0, 0, "R9");
      slow = 1; pt_set = 1; go(0, 0, "R9");
      pt_set = 0; go(1, 0, "R9");
      rlow = 0; slow = 0; pt_rst = 0; pt_set = 0; grst = 0; go(1, 0, "R9");

      // R11 clear beats preset
      pt_set = 1; pt_rst = 1; go(0, 0, "R11");
      pt_rst = 0; go(1, 0, "R11");
      pt_set = 0; go(1, 0, "R11");

      // R10 global line action
      gsets = 0; grst = 1; go(0, 0, "R10");
      grst = 0; go(0, 0, "R10");
      gsets = 1; grst = 1; go(1, 0, "R10");
      grst = 0; go(1, 0, "R10");
      grst = 1; pt_rst = 1; go(0, 0, "R11");
      grst = 0; pt_rst = 0; go(0, 0, "R11");

      @(posedge clk);
      #2;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule